// File: doc/BRIEF.md
# Interrupt Line Message Generator

This block turns a handful of interrupt input wires into memory-write interrupt messages. Each line owns a 64-bit redirection entry, loaded through a configuration write port. The entry holds the vector, the delivery mode, the destination mode, the trigger mode, a mask bit and the destination ID. When a line needs attention, the block formats a 32-bit address word and a 32-bit data word from that line's entry. It presents the pair on a valid/ready port, and only one message is outstanding at any time.

Lines set to edge trigger send a single assert message per rising transition of the synchronised input. Lines set to level trigger follow the pin: they send a message each time the synchronised state differs from the state they last delivered, so both assertion and deassertion reach the receiver. When several lines want service at once, the lowest-numbered line is served first. The receiver side, the bus transport and any end-of-interrupt return path sit outside this block.

Top module: `irq_msg_gen`

## Requirements
- R1: Address word layout: bits 31:20 equal the ADDR_BASE parameter (default FEEh), bits 19:12 are zero, bits 11:4 copy entry bits 55:48 (destination ID), and bits 1:0 are 00.
- R2: Address bit 3 (redirect hint) is 1 exactly when entry bits 10:8 equal 001 (lowest priority). Address bit 2 equals the entry's destination-mode bit (entry bit 11) when the hint is 1, and is 0 otherwise.
- R3: Data word layout: bits 31:16 and 13:12 are zero. Bit 15 copies the trigger bit (entry bit 15, 1 = level). Bit 11 copies the destination mode (entry bit 11, 1 = logical). Bits 10:8 copy the delivery mode (entry 10:8). Bits 7:0 copy the vector (entry 7:0).
- R4: An edge line (entry bit 15 = 0) sends exactly one message with data bit 14 = 1 per rising transition of its synchronised input. Holding the pin high sends nothing further, and a falling transition sends nothing.
- R5: A level line (entry bit 15 = 1) sends a message whenever its synchronised input differs from the state it last delivered, with data bit 14 equal to that input state.
- R6: If a level pin changes again while its message is stalled, a further message carrying the new state follows once the stalled one is accepted.
- R7: Among lines requesting at the same time, the lowest-numbered line's message is issued first.
- R8: While an entry's mask bit (entry bit 16) is 1, the line sends no message. Edges seen while masked are discarded, and a level change while masked is not sent until unmasked.
- R9: When a level line goes from masked to unmasked, it sends its current state once, even if that state equals the last state it delivered.
- R10: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and msg_addr and msg_data hold their values.
- R11: After reset msg_valid is 0 and every entry is zero apart from its mask bit being 1, so no line sends anything until it is configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Interrupt input wires, asynchronous |
| cfg_we | input | 1 | Entry write strobe |
| cfg_sel | input | SEL_W | Index of the entry to write |
| cfg_entry | input | 64 | New entry contents |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message address word |
| msg_data | output | 32 | Message data word |

## Verification
The hardest case to reach from the ports is a level pin that changes again while its own message is stalled. It must produce a trailing message carrying the new state, not be lost, and not repeat the old state. The stimulus holds msg_ready low, raises a level pin, lets the message appear, and drops the pin during the stall before releasing ready. The unmask-with-no-change case is reached by masking and unmasking a quiet level line through configuration writes alone. Arbitration is exercised by raising two edge lines in the same cycle while ready is low.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    localparam int ENTRY_W   = 64;
    localparam int VEC_LSB   = 0;
    localparam int DLM_LSB   = 8;
    localparam int DSTM_BIT  = 11;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LSB  = 48;
    localparam logic [2:0] DLM_LOWEST = 3'b001;

    typedef logic [ENTRY_W-1:0] entry_t;

    localparam entry_t ENTRY_RESET = entry_t'(1) << MASK_BIT;

    // Address word built from an entry; hint derived from delivery mode.
    function automatic logic [31:0] form_addr(entry_t e, logic [11:0] base);
        logic hint;
        hint = (e[DLM_LSB +: 3] == DLM_LOWEST);
        return {base, 8'h00, e[DEST_LSB +: 8], hint, hint & e[DSTM_BIT], 2'b00};
    endfunction

    // Data word built from an entry and the delivered state.
    function automatic logic [31:0] form_data(entry_t e, logic state);
        return {16'h0000, e[TRIG_BIT], state, 2'b00, e[DSTM_BIT],
                e[DLM_LSB +: 3], e[VEC_LSB +: 8]};
    endfunction

endpackage

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic level_mode,
    input  logic mask,
    input  logic ack,
    input  logic ack_state,
    output logic req,
    output logic cur_state
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   pend;
        logic                   sent;
        logic                   refresh;
        logic                   mask_prev;
    } line_st_t;

    line_st_t st_q, st_d;
    logic     synced, rise;

    assign synced = st_q.sync[SYNC_STAGES-1];
    assign rise   = synced & ~st_q.prev;

    always_comb begin
        st_d           = st_q;
        st_d.sync      = {st_q.sync[SYNC_STAGES-2:0], pin};
        st_d.prev      = synced;
        st_d.mask_prev = mask;
        if (level_mode) begin
            st_d.pend = 1'b0;
            if (ack) begin
                st_d.sent    = ack_state;
                st_d.refresh = 1'b0;
            end
            if (st_q.mask_prev && !mask) st_d.refresh = 1'b1;
        end else begin
            st_d.refresh = 1'b0;
            if (ack) st_d.pend = 1'b0;
            if (rise && !mask) st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.mask_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req       = ~mask & (level_mode ? ((synced != st_q.sent) | st_q.refresh) : st_q.pend);
    assign cur_state = synced;

    // R5: after a level message is accepted the line remembers the delivered state
    a_r5_sent_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && level_mode) |=> (st_q.sent == $past(ack_state)));

    // R4: an accepted edge request with no new edge leaves nothing pending
    a_r4_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !level_mode && !rise) |=> !st_q.pend);

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int NUM_REQ = 4
) (
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] gnt,
    output logic               any
);

    always_comb begin
        gnt = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req[i]) gnt = NUM_REQ'(1) << i;
        end
    end

    assign any = |req;

endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen
    import irq_msg_pkg::*;
#(
    parameter int          NUM_LINES   = 4,
    parameter int          SYNC_STAGES = 2,
    parameter logic [11:0] ADDR_BASE   = 12'hFEE,
    localparam int         SEL_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [63:0]          cfg_entry,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [31:0]          msg_addr,
    output logic [31:0]          msg_data
);

    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] line;
        logic [31:0]      addr;
        logic [31:0]      data;
    } out_st_t;

    out_st_t              out_q, out_d;
    entry_t               entry_q [NUM_LINES];
    entry_t               entry_d [NUM_LINES];
    logic [NUM_LINES-1:0] line_req, line_state, ack_vec, gnt;
    logic                 any_req;
    logic [SEL_W-1:0]     gnt_idx;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (irq_in[g]),
            .level_mode(entry_q[g][TRIG_BIT]),
            .mask      (entry_q[g][MASK_BIT]),
            .ack       (ack_vec[g]),
            .ack_state (out_q.data[14]),
            .req       (line_req[g]),
            .cur_state (line_state[g])
        );
    end

    irq_prio_arb #(.NUM_REQ(NUM_LINES)) u_arb (
        .req(line_req),
        .gnt(gnt),
        .any(any_req)
    );

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (gnt[i]) gnt_idx = SEL_W'(i);
        end
    end

    always_comb begin
        out_d   = out_q;
        ack_vec = '0;
        for (int i = 0; i < NUM_LINES; i++) entry_d[i] = entry_q[i];
        if (cfg_we && (32'(cfg_sel) < NUM_LINES)) entry_d[cfg_sel] = cfg_entry;
        if (out_q.valid && msg_ready) begin
            out_d.valid         = 1'b0;
            ack_vec[out_q.line] = 1'b1;
        end
        if (!out_q.valid && any_req) begin
            out_d.valid = 1'b1;
            out_d.line  = gnt_idx;
            out_d.addr  = form_addr(entry_q[gnt_idx], ADDR_BASE);
            out_d.data  = form_data(entry_q[gnt_idx],
                              entry_q[gnt_idx][TRIG_BIT] ? line_state[gnt_idx] : 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) entry_q[i] <= ENTRY_RESET;
        end else begin
            out_q <= out_d;
            for (int i = 0; i < NUM_LINES; i++) entry_q[i] <= entry_d[i];
        end
    end

    assign msg_valid = out_q.valid;
    assign msg_addr  = out_q.addr;
    assign msg_data  = out_q.data;

    // R10: a stalled message does not move
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R7: the arbiter grants at most one line, and only a requesting one
    a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~line_req) == '0));

    // R7: any request yields a grant
    a_r7_grant_live: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> (gnt != '0));

    // R2: hint in the address agrees with the delivery mode in the data
    a_r2_hint: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[3] == (msg_data[10:8] == DLM_LOWEST)));

    // R2: destination mode bit in the address only appears with the hint
    a_r2_dm_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_addr[3]) |-> !msg_addr[2]);

    // R4: edge messages always carry the asserted status
    a_r4_edge_status: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_data[15]) |-> msg_data[14]);

endmodule

// File: tb/sim_irq_msg_gen.sv
module sim_irq_msg_gen;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [63:0] cfg_entry = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [31:0] msg_addr, msg_data;

    int checks = 0;
    int fails  = 0;
    logic [63:0] expq[$];
    logic [63:0] ent [N];
    logic        was_stalled = 1'b0;
    logic [31:0] last_addr, last_data;
    logic        mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_msg_gen #(.NUM_LINES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_entry(cfg_entry),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [63:0] mk(input logic [7:0] dest, input logic msk,
                                       input logic lvl, input logic dstm,
                                       input logic [2:0] dlm, input logic [7:0] vec);
        logic [63:0] e;
        e = '0;
        e[55:48] = dest; e[16] = msk; e[15] = lvl;
        e[11] = dstm; e[10:8] = dlm; e[7:0] = vec;
        return e;
    endfunction

    // Expected message from the requirement text (R1, R2, R3)
    function automatic logic [63:0] want(input int ln, input logic st);
        logic [31:0] a, d;
        logic h;
        h = (ent[ln][10:8] == 3'd1);
        a = 32'h0;
        a[31:20] = 12'hFEE;
        a[11:4]  = ent[ln][55:48];
        a[3]     = h;
        a[2]     = h ? ent[ln][11] : 1'b0;
        d = 32'h0;
        d[15]   = ent[ln][15];
        d[14]   = st;
        d[11]   = ent[ln][11];
        d[10:8] = ent[ln][10:8];
        d[7:0]  = ent[ln][7:0];
        return {a, d};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the expected message stream
    always @(negedge clk) begin
        if (mon_on) begin
            if (was_stalled) begin
                check(msg_valid && msg_addr == last_addr && msg_data == last_data, "R10",
                      {msg_addr, msg_data}, {last_addr, last_data});
            end
            if (msg_valid && msg_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R8 unexpected message", {msg_addr, msg_data}, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = expq.pop_front();
                    check({msg_addr, msg_data} == e, "R1/R2/R3 message", {msg_addr, msg_data}, e);
                end
            end
            was_stalled = msg_valid && !msg_ready;
            last_addr   = msg_addr;
            last_data   = msg_data;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int ln, input logic [63:0] e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(ln); cfg_entry = e; ent[ln] = e;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drained(input string req);
        cyc(20);
        check(expq.size() == 0, req, 64'(expq.size()), 64'h0);
    endtask

    task automatic quiet(input int n, input string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(!seen, req, 64'(seen), 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) ent[i] = 64'h0000_0000_0001_0000;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(!msg_valid, "R11 reset valid", 64'(msg_valid), 64'h0);
        mon_on = 1'b1;

        // R11: unconfigured lines are masked
        irq_in = 4'b1111; cyc(4); irq_in = '0;
        quiet(15, "R11 masked after reset");

        // Configure; level lines 1 and 3 send their state once on unmask (R9)
        wr(0, mk(8'h11, 1'b0, 1'b0, 1'b0, 3'd0, 8'h30));
        wr(1, mk(8'h22, 1'b0, 1'b1, 1'b1, 3'd1, 8'h41));
        expq.push_back(want(1, 1'b0));
        wr(2, mk(8'h33, 1'b0, 1'b0, 1'b0, 3'd1, 8'h52));
        wr(3, mk(8'h44, 1'b0, 1'b1, 1'b1, 3'd0, 8'h63));
        expq.push_back(want(3, 1'b0));
        drained("R9 initial unmask");

        // R4: edge line held high gives one message, falling gives none
        expq.push_back(want(0, 1'b1));
        irq_in[0] = 1'b1; cyc(15); irq_in[0] = 1'b0;
        drained("R4 single edge message");

        // R5 with R2 hint set (line 1 lowest priority, logical)
        expq.push_back(want(1, 1'b1));
        irq_in[1] = 1'b1; cyc(15);
        expq.push_back(want(1, 1'b0));
        irq_in[1] = 1'b0;
        drained("R5 level assert and deassert");

        // R6: level change while stalled
        msg_ready = 1'b0;
        irq_in[3] = 1'b1; cyc(10);
        check(msg_valid, "R6 stalled message present", 64'(msg_valid), 64'h1);
        irq_in[3] = 1'b0; cyc(10);
        expq.push_back(want(3, 1'b1));
        expq.push_back(want(3, 1'b0));
        msg_ready = 1'b1;
        drained("R6 trailing level message");

        // R7: two edge lines together, lower index first
        msg_ready = 1'b0;
        irq_in[2] = 1'b1; irq_in[0] = 1'b1;
        cyc(10);
        expq.push_back(want(0, 1'b1));
        expq.push_back(want(2, 1'b1));
        msg_ready = 1'b1;
        drained("R7 priority order");
        irq_in[2] = 1'b0; irq_in[0] = 1'b0;
        quiet(15, "R4 falling edges silent");

        // R8: masked edge is discarded
        wr(0, mk(8'h11, 1'b1, 1'b0, 1'b0, 3'd0, 8'h30));
        irq_in[0] = 1'b1; cyc(5); irq_in[0] = 1'b0;
        quiet(10, "R8 masked edge");
        wr(0, mk(8'h11, 1'b0, 1'b0, 1'b0, 3'd0, 8'h30));
        quiet(15, "R8 edge lost after unmask");

        // R8 then R9: level change while masked, sent on unmask
        wr(3, mk(8'h44, 1'b1, 1'b1, 1'b1, 3'd0, 8'h63));
        irq_in[3] = 1'b1;
        quiet(15, "R8 masked level");
        expq.push_back(want(3, 1'b1));
        wr(3, mk(8'h44, 1'b0, 1'b1, 1'b1, 3'd0, 8'h63));
        drained("R9 level sent on unmask");

        // R9: unmask with unchanged state still sends once
        wr(1, mk(8'h22, 1'b1, 1'b1, 1'b1, 3'd1, 8'h41));
        cyc(5);
        expq.push_back(want(1, 1'b0));
        wr(1, mk(8'h22, 1'b0, 1'b1, 1'b1, 3'd1, 8'h41));
        drained("R9 unchanged state resent once");
        quiet(10, "R9 only once");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule